// File: doc/BRIEF.md
# Instruction Prefix State Holder

This block keeps the state that single-byte instruction prefixes leave behind, so that it applies to the instruction that follows them. An opcode classifier upstream raises one term line for each kind of prefix (repeat, segment override, bus lock) and one for the interrupt-disable instruction. Its results are valid in the second decode clock, which `sc_stb` marks. The block samples those terms together with the relevant opcode bits and sets sticky latches. The latches survive the end of the prefix itself and of any further prefixes. They clear at the end of the first instruction that is not a prefix.

While any prefix state is held, and in the classification cycle of a prefix or interrupt-disable opcode, the block raises an interrupt-block output. This output is combinational in that cycle. Interrupts therefore cannot be accepted between a prefix and the instruction it modifies. They also cannot be accepted between the interrupt-disable opcode and the clearing of the flag elsewhere. The string iteration engine and the bus lock hardware consume the outputs and sit outside this block.

Top module: `prefix_hold_unit`

## Requirements
- R1: After reset every output is 0 while no strobe is applied.
- R2: A cycle with `sc_stb` and `rep_term` high sets `rep_on` at the next edge and loads `rep_zero` from `op_lsb` (1 means repeat while zero, 0 means repeat while not zero).
- R3: A cycle with `sc_stb` and `seg_term` high sets `seg_valid` at the next edge and loads `seg_code` from `op_seg` (opcode bits 4..3): 00 extra, 01 code, 10 stack, 11 data segment.
- R4: A cycle with `sc_stb` and `lock_term` high raises `lock_out` at the next edge.
- R5: Successive prefixes accumulate, so repeat, segment and lock state are held together.
- R6: A later segment prefix replaces the code of an earlier one.
- R7: The `eoi_stb` of a prefix leaves the latches unchanged. The `eoi_stb` of the next non-prefix instruction clears all of them at the following edge.
- R8: `irq_block` is high in the same cycle as `sc_stb` with any prefix term. It stays high while any latch is held and falls when the latches clear.
- R9: `irq_block` is high in the same cycle as `sc_stb` with `cli_term`. It stays high until the edge of that instruction's `eoi_stb`.
- R10: Term lines without `sc_stb` have no effect on any output.
- R11: When an `eoi_stb` of a non-prefix instruction coincides with `sc_stb` of a new prefix, the old state clears and the new prefix's latch is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sc_stb | input | 1 | Classifier outputs valid (second decode clock) |
| eoi_stb | input | 1 | Current instruction ends this cycle |
| rep_term | input | 1 | Classifier: repeat prefix |
| seg_term | input | 1 | Classifier: segment override prefix |
| lock_term | input | 1 | Classifier: bus lock prefix |
| cli_term | input | 1 | Classifier: interrupt-disable opcode |
| op_lsb | input | 1 | Opcode bit 0 |
| op_seg | input | SEG_W | Opcode bits 4..3 |
| rep_on | output | 1 | Repeat prefix pending |
| rep_zero | output | 1 | Repeat condition: 1 while zero, 0 while not zero |
| seg_valid | output | 1 | Segment override pending |
| seg_code | output | SEG_W | Selected override segment |
| lock_out | output | 1 | Bus lock requested |
| irq_block | output | 1 | Interrupt acceptance blocked |

## Verification
The hardest case to reach is the overlap, where the end of a plain instruction falls in the same cycle as the classification of a following prefix. Here the block must clear the old state and set the new state at once. The stimulus reaches it by running a prefix, then a plain instruction through its classification cycle, and then driving `eoi_stb` together with `sc_stb` and a lock term. After that cycle, repeat state must be gone and lock set. The case where a prefix's own end must not clear anything is reached by stacking several prefixes, each followed by its own end strobe.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  parameter int SEG_W = 2;

  typedef enum logic [SEG_W-1:0] {
    SEG_EXTRA = 2'b00,
    SEG_CODE  = 2'b01,
    SEG_STACK = 2'b10,
    SEG_DATA  = 2'b11
  } seg_e;
endpackage

// File: rtl/pfx_sticky.sv
module pfx_sticky #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] d_i,
  output logic         vld_o,
  output logic [W-1:0] q_o
);
  logic         vld_d;
  logic [W-1:0] q_d;
  logic         en;

  // set wins over clear so an overlapping new prefix survives
  always_comb begin
    vld_d = vld_o;
    q_d   = q_o;
    if (set_i) begin
      vld_d = 1'b1;
      q_d   = d_i;
    end else if (clr_i) begin
      vld_d = 1'b0;
      q_d   = '0;
    end
  end

  assign en = set_i | clr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      q_o   <= '0;
    end else if (en) begin
      vld_o <= vld_d;
      q_o   <= q_d;
    end
  end
endmodule

// File: rtl/pfx_scope_ctrl.sv
module pfx_scope_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic sc_i,
  input  logic eoi_i,
  input  logic pfx_term_i,
  input  logic cli_term_i,
  output logic clr_o,
  output logic cli_hold_o
);
  logic cur_pfx_q, cur_pfx_d;
  logic cli_d;

  // cur_pfx_q describes the instruction now in flight
  always_comb begin
    cur_pfx_d = cur_pfx_q;
    if (sc_i) cur_pfx_d = pfx_term_i;
    cli_d = cli_hold_o;
    if (eoi_i) cli_d = 1'b0;
    if (sc_i && cli_term_i) cli_d = 1'b1;
  end

  assign clr_o = eoi_i & ~cur_pfx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_pfx_q  <= 1'b0;
      cli_hold_o <= 1'b0;
    end else begin
      if (sc_i) cur_pfx_q <= cur_pfx_d;
      if (sc_i || eoi_i) cli_hold_o <= cli_d;
    end
  end
endmodule

// File: rtl/prefix_hold_unit.sv
module prefix_hold_unit #(
  parameter int SEG_W = pfx_pkg::SEG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sc_stb,
  input  logic             eoi_stb,
  input  logic             rep_term,
  input  logic             seg_term,
  input  logic             lock_term,
  input  logic             cli_term,
  input  logic             op_lsb,
  input  logic [SEG_W-1:0] op_seg,
  output logic             rep_on,
  output logic             rep_zero,
  output logic             seg_valid,
  output logic [SEG_W-1:0] seg_code,
  output logic             lock_out,
  output logic             irq_block
);
  logic any_pfx;
  logic clr;
  logic cli_hold;
  logic lock_vld, lock_q;

  assign any_pfx = rep_term | seg_term | lock_term;

  pfx_scope_ctrl u_scope (
    .clk        (clk),
    .rst_n      (rst_n),
    .sc_i       (sc_stb),
    .eoi_i      (eoi_stb),
    .pfx_term_i (any_pfx),
    .cli_term_i (cli_term),
    .clr_o      (clr),
    .cli_hold_o (cli_hold)
  );

  pfx_sticky #(.W(1)) u_rep (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (sc_stb & rep_term),
    .clr_i (clr),
    .d_i   (op_lsb),
    .vld_o (rep_on),
    .q_o   (rep_zero)
  );

  pfx_sticky #(.W(SEG_W)) u_seg (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (sc_stb & seg_term),
    .clr_i (clr),
    .d_i   (op_seg),
    .vld_o (seg_valid),
    .q_o   (seg_code)
  );

  pfx_sticky #(.W(1)) u_lock (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (sc_stb & lock_term),
    .clr_i (clr),
    .d_i   (1'b1),
    .vld_o (lock_vld),
    .q_o   (lock_q)
  );

  assign lock_out  = lock_vld & lock_q;
  assign irq_block = rep_on | seg_valid | lock_out | cli_hold
                   | (sc_stb & (any_pfx | cli_term));
endmodule

// File: rtl/pfx_hold_chk.sv
module pfx_hold_chk #(
  parameter int SEG_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sc_stb,
  input logic             eoi_stb,
  input logic             rep_term,
  input logic             seg_term,
  input logic             lock_term,
  input logic             cli_term,
  input logic             op_lsb,
  input logic [SEG_W-1:0] op_seg,
  input logic             rep_on,
  input logic             rep_zero,
  input logic             seg_valid,
  input logic [SEG_W-1:0] seg_code,
  input logic             lock_out,
  input logic             irq_block
);
  AST_REP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_stb && rep_term) |=> (rep_on && rep_zero == $past(op_lsb))); // R2
  AST_SEG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_stb && seg_term) |=> (seg_valid && seg_code == $past(op_seg))); // R3
  AST_LOCK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_stb && lock_term) |=> lock_out); // R4
  AST_BLOCK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_on || seg_valid || lock_out) |-> irq_block); // R8
  AST_CLI_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_stb && cli_term) |-> irq_block); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sc_stb && !eoi_stb) |=> ($stable(rep_on) && $stable(seg_valid)
                               && $stable(seg_code) && $stable(lock_out))); // R10
endmodule

bind prefix_hold_unit pfx_hold_chk #(.SEG_W(SEG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sc_stb(sc_stb), .eoi_stb(eoi_stb),
  .rep_term(rep_term), .seg_term(seg_term), .lock_term(lock_term),
  .cli_term(cli_term), .op_lsb(op_lsb), .op_seg(op_seg),
  .rep_on(rep_on), .rep_zero(rep_zero), .seg_valid(seg_valid),
  .seg_code(seg_code), .lock_out(lock_out), .irq_block(irq_block)
);

// File: tb/sim_prefix_hold_unit.sv
`timescale 1ns/1ps
module sim_prefix_hold_unit;
  logic clk, rst_n;
  logic sc_stb, eoi_stb, rep_term, seg_term, lock_term, cli_term, op_lsb;
  logic [1:0] op_seg;
  logic rep_on, rep_zero, seg_valid, lock_out, irq_block;
  logic [1:0] seg_code;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  prefix_hold_unit u0 (.*);

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(bit sc, bit eoi, bit r, bit s, bit l, bit c, bit b0, logic [1:0] sg);
    sc_stb = sc; eoi_stb = eoi; rep_term = r; seg_term = s;
    lock_term = l; cli_term = c; op_lsb = b0; op_seg = sg;
  endtask

  task automatic idle();
    drive(0,0,0,0,0,0,0,2'b00);
  endtask

  // inputs applied after a falling edge; advance to the next falling edge
  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic prefix(bit r, bit s, bit l, bit b0, logic [1:0] sg);
    drive(1,0,r,s,l,0,b0,sg);
    #1 chk("R8", irq_block, 1);
    tick();
    drive(0,1,0,0,0,0,0,2'b00);
    tick();
  endtask

  task automatic plain_start();
    drive(1,0,0,0,0,0,0,2'b00);
    tick();
  endtask

  task automatic plain_end();
    drive(0,1,0,0,0,0,0,2'b00);
    tick();
  endtask

  task automatic t_reset();
    chk("R1 rep_on", rep_on, 0);
    chk("R1 seg_valid", seg_valid, 0);
    chk("R1 lock_out", lock_out, 0);
    chk("R1 irq_block", irq_block, 0);
  endtask

  task automatic t_rep(bit b0);
    prefix(1,0,0,b0,2'b00);
    chk("R2 rep_on", rep_on, 1);
    chk("R2 rep_zero", rep_zero, b0);
    chk("R7 kept after own end", rep_on, 1);
    plain_start();
    chk("R7 kept during next", rep_on, 1);
    chk("R8 held", irq_block, 1);
    plain_end();
    chk("R7 cleared", rep_on, 0);
    chk("R8 released", irq_block, 0);
  endtask

  task automatic t_seg();
    for (int i = 0; i < 4; i++) begin
      prefix(0,1,0,0,2'(i));
      chk("R3 seg_valid", seg_valid, 1);
      chk("R3 seg_code", seg_code, i);
      plain_start();
      plain_end();
      chk("R7 seg cleared", seg_valid, 0);
    end
  endtask

  task automatic t_lock();
    prefix(0,0,1,0,2'b00);
    chk("R4 lock_out", lock_out, 1);
    plain_start();
    plain_end();
    chk("R7 lock cleared", lock_out, 0);
  endtask

  task automatic t_stack();
    prefix(1,0,0,1,2'b00);
    prefix(0,1,0,0,2'b01);
    prefix(0,0,1,0,2'b00);
    prefix(0,1,0,0,2'b11);
    chk("R5 rep kept", rep_on, 1);
    chk("R5 rep_zero kept", rep_zero, 1);
    chk("R5 lock kept", lock_out, 1);
    chk("R6 seg replaced", seg_code, 3);
    plain_start();
    plain_end();
    chk("R7 all cleared", {rep_on, seg_valid, lock_out}, 0);
  endtask

  task automatic t_ignore();
    drive(0,0,1,1,1,0,1,2'b10);
    #1 chk("R10 no block without strobe", irq_block, 0);
    tick();
    chk("R10 rep untouched", rep_on, 0);
    chk("R10 seg untouched", seg_valid, 0);
    prefix(0,1,0,0,2'b10);
    drive(0,0,0,1,0,0,0,2'b01);
    tick();
    chk("R10 seg code kept", seg_code, 2);
    plain_start();
    plain_end();
  endtask

  task automatic t_cli();
    drive(1,0,0,0,0,1,0,2'b00);
    #1 chk("R9 same cycle", irq_block, 1);
    tick();
    chk("R9 held", irq_block, 1);
    plain_end();
    chk("R9 released", irq_block, 0);
  endtask

  task automatic t_overlap();
    prefix(1,0,0,0,2'b00);
    plain_start();
    drive(1,1,0,0,1,0,0,2'b00);
    tick();
    chk("R11 old cleared", rep_on, 0);
    chk("R11 new set", lock_out, 1);
    plain_start();
    plain_end();
    chk("R11 then cleared", lock_out, 0);
  endtask

  initial begin
    #150000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_rep(0);
    t_rep(1);
    t_seg();
    t_lock();
    t_stack();
    t_ignore();
    t_cli();
    t_overlap();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule